// File: doc/BRIEF.md
# Fieldbus Slave Application-State Controller

This block holds the application-layer state of an industrial fieldbus slave. The bus master asks for a new state by putting a state code on `req_state` and pulsing `req_valid`. The block checks whether the move from the current state is legal. It then tests the preconditions that the target state needs, such as valid channel configuration, valid clock configuration, or output data already received. It either performs the move or refuses it. Every request gets a one-cycle `ack`, and the error flag and error code with it tell whether the request was refused.

The current state decides which traffic may pass. It enables mailbox traffic, enables process data, refreshes the input snapshot, and decides whether the physical output word follows the master's data or is held at the safe all-zero value.

Requests are a plain strobe with no ready signal. The block answers every strobe, so there is no back-pressure. The data words are level signals that are sampled each cycle.

Top module: `slave_state_ctrl`

## Requirements
- R1: After reset, `cur_state` is Init (4'h1), `ack`, `err` and `err_code` are 0, `mbx_en` and `pd_en` are 0, and `out_word` is 0.
- R2: The valid state codes are Init=4'h1, Pre-Op=4'h2, Boot=4'h3, Safe-Op=4'h4 and Op=4'h8. A request with any other code is refused with `err_code` 4'h1 (illegal).
- R3: Boot is entered only from Init. A Boot request from another state is refused with code 4'h1. From Boot, the only move accepted is to Init.
- R4: A Pre-Op to Safe-Op request is accepted only when `chan_cfg_ok` is 1, and also `clk_cfg_ok` is 1 if `clk_sync_en` is 1. Otherwise it is refused with code 4'h2.
- R5: On the edge that accepts Pre-Op to Safe-Op, `in_snap` captures `in_word`. While the state is Safe-Op or Op, `in_snap` recaptures `in_word` on every edge. In the other states it holds its value.
- R6: `out_word` is 0 in Init, Pre-Op and Boot. In Safe-Op it is 0 when `wdog_en` is 1, and it equals `master_word` when `wdog_en` is 0.
- R7: A Safe-Op to Op request is accepted only when `out_data_ok` is 1. Otherwise it is refused with code 4'h3.
- R8: In Op, `out_word` equals `master_word`, and `mbx_en` and `pd_en` are both 1.
- R9: In Boot, `mbx_en` is 1 only when `mbx_type` equals the file-access type (4'h4 by default), and `pd_en` is 0. In Init, `mbx_en` and `pd_en` are 0. In Pre-Op, `mbx_en` is 1 for every type and `pd_en` is 0.
- R10: `ack` is 1 for exactly one cycle, in the cycle after each request. A refused request leaves the state unchanged, sets `err` and sets the error code. The next accepted request clears both.
- R11: Downward moves are always accepted at the request edge: Op to Safe-Op, Safe-Op or Op to Pre-Op, and any state to Init. A move out of Op zeroes `out_word` in the same cycle that `cur_state` changes, unless the new state is Safe-Op with `wdog_en` at 0.
- R12: Upward skips are refused with code 4'h1. Examples are Init to Safe-Op, Init to Op and Pre-Op to Op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | State-change request strobe |
| req_state | input | 4 | Requested state code |
| chan_cfg_ok | input | 1 | Process-data channel configuration valid |
| clk_sync_en | input | 1 | Distributed clocking enabled |
| clk_cfg_ok | input | 1 | Clock configuration valid |
| wdog_en | input | 1 | Output watchdog enabled |
| out_data_ok | input | 1 | Valid output data received from master |
| mbx_type | input | 4 | Protocol type of the current mailbox frame |
| in_word | input | DW | Live input data |
| master_word | input | DW | Output data from the master |
| cur_state | output | 4 | Current state code |
| ack | output | 1 | Request answered (one cycle) |
| err | output | 1 | Last request refused |
| err_code | output | 4 | 0 none, 1 illegal, 2 configuration invalid, 3 outputs not valid |
| mbx_en | output | 1 | Mailbox frame of `mbx_type` accepted |
| pd_en | output | 1 | Process-data traffic enabled |
| in_snap | output | DW | Input process-data snapshot |
| out_word | output | DW | Physical output word |

## Verification
The bench drives a request on a falling edge, and the rising edge that follows registers it. `cur_state`, `ack`, `err`, `err_code` and the snapshot therefore change one edge after the request, and the bench samples them on the next falling edge. `mbx_en`, `pd_en` and `out_word` are combinational from the registered state and the live inputs. They are checked half a cycle after a state change or after an input change. The refresh of `in_snap` in Safe-Op and Op is checked one edge after `in_word` changes, and the hold in the other states is checked one edge after a change that must be ignored.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [3:0] {
    ST_INIT   = 4'h1,
    ST_PREOP  = 4'h2,
    ST_BOOT   = 4'h3,
    ST_SAFEOP = 4'h4,
    ST_OP     = 4'h8
  } ap_state_e;

  typedef enum logic [3:0] {
    ERR_NONE       = 4'h0,
    ERR_ILLEGAL    = 4'h1,
    ERR_CONFIG     = 4'h2,
    ERR_NO_OUTPUTS = 4'h3
  } ap_err_e;

  typedef struct packed {
    logic      accept;
    ap_err_e   code;
    ap_state_e next;
  } ap_verdict_t;
endpackage

// File: rtl/ap_trans_judge.sv
module ap_trans_judge
  import fsc_pkg::*;
(
  input  ap_state_e   cur,
  input  logic [3:0]  req_code,
  input  logic        chan_cfg_ok,
  input  logic        clk_sync_en,
  input  logic        clk_cfg_ok,
  input  logic        out_data_ok,
  output ap_verdict_t verdict
);
  logic      known;
  logic      ok;
  ap_err_e   why;
  ap_state_e want;

  always_comb begin
    case (req_code)
      4'h1, 4'h2, 4'h3, 4'h4, 4'h8: known = 1'b1;
      default:                      known = 1'b0;
    endcase
    want = ap_state_e'(req_code);
    ok   = 1'b0;
    why  = ERR_ILLEGAL;
    if (known) begin
      if (want == cur) begin
        ok = 1'b1;
      end else begin
        case (want)
          ST_INIT:  ok = 1'b1;
          ST_PREOP: ok = (cur == ST_INIT) || (cur == ST_SAFEOP) || (cur == ST_OP);
          ST_BOOT:  ok = (cur == ST_INIT);
          ST_SAFEOP: begin
            if (cur == ST_OP) ok = 1'b1;
            else if (cur == ST_PREOP) begin
              ok  = chan_cfg_ok && (!clk_sync_en || clk_cfg_ok);
              why = ERR_CONFIG;
            end
          end
          ST_OP: begin
            if (cur == ST_SAFEOP) begin
              ok  = out_data_ok;
              why = ERR_NO_OUTPUTS;
            end
          end
          default: ok = 1'b0;
        endcase
      end
    end
    verdict.accept = ok;
    verdict.code   = ok ? ERR_NONE : why;
    verdict.next   = ok ? want : cur;
  end
endmodule

// File: rtl/ap_state_keeper.sv
module ap_state_keeper
  import fsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  ap_verdict_t verdict,
  output ap_state_e   state,
  output logic        ack,
  output logic        err,
  output ap_err_e     err_code,
  output logic        snap_load
);
  assign snap_load = req_valid && verdict.accept &&
                     (state == ST_PREOP) && (verdict.next == ST_SAFEOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_INIT;
      ack      <= 1'b0;
      err      <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      ack <= req_valid;
      if (req_valid) begin
        state    <= verdict.next;
        err      <= !verdict.accept;
        err_code <= verdict.code;
      end
    end
  end
endmodule

// File: rtl/ap_data_gate.sv
module ap_data_gate
  import fsc_pkg::*;
#(
  parameter int         DW        = 16,
  parameter int         TW        = 4,
  parameter logic [3:0] FILE_TYPE = 4'h4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ap_state_e     state,
  input  logic          snap_load,
  input  logic          wdog_en,
  input  logic [TW-1:0] mbx_type,
  input  logic [DW-1:0] in_word,
  input  logic [DW-1:0] master_word,
  output logic          mbx_en,
  output logic          pd_en,
  output logic [DW-1:0] in_snap,
  output logic [DW-1:0] out_word
);
  logic live_pd;
  logic drive_out;

  assign live_pd   = (state == ST_SAFEOP) || (state == ST_OP);
  assign drive_out = (state == ST_OP) || ((state == ST_SAFEOP) && !wdog_en);
  assign pd_en     = live_pd;
  assign out_word  = drive_out ? master_word : '0;

  always_comb begin
    case (state)
      ST_INIT: mbx_en = 1'b0;
      ST_BOOT: mbx_en = (mbx_type == TW'(FILE_TYPE));
      default: mbx_en = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    in_snap <= '0;
    else if (snap_load || live_pd) in_snap <= in_word;
  end
endmodule

// File: rtl/slave_state_ctrl.sv
module slave_state_ctrl
  import fsc_pkg::*;
#(
  parameter int         DW        = 16,
  parameter logic [3:0] FILE_TYPE = 4'h4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_state,
  input  logic          chan_cfg_ok,
  input  logic          clk_sync_en,
  input  logic          clk_cfg_ok,
  input  logic          wdog_en,
  input  logic          out_data_ok,
  input  logic [3:0]    mbx_type,
  input  logic [DW-1:0] in_word,
  input  logic [DW-1:0] master_word,
  output logic [3:0]    cur_state,
  output logic          ack,
  output logic          err,
  output logic [3:0]    err_code,
  output logic          mbx_en,
  output logic          pd_en,
  output logic [DW-1:0] in_snap,
  output logic [DW-1:0] out_word
);
  ap_state_e   state;
  ap_verdict_t verdict;
  ap_err_e     code;
  logic        snap_load;

  ap_trans_judge u_judge (
    .cur(state), .req_code(req_state), .chan_cfg_ok(chan_cfg_ok),
    .clk_sync_en(clk_sync_en), .clk_cfg_ok(clk_cfg_ok),
    .out_data_ok(out_data_ok), .verdict(verdict)
  );

  ap_state_keeper u_keeper (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .verdict(verdict),
    .state(state), .ack(ack), .err(err), .err_code(code),
    .snap_load(snap_load)
  );

  ap_data_gate #(.DW(DW), .TW(4), .FILE_TYPE(FILE_TYPE)) u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .snap_load(snap_load),
    .wdog_en(wdog_en), .mbx_type(mbx_type), .in_word(in_word),
    .master_word(master_word), .mbx_en(mbx_en), .pd_en(pd_en),
    .in_snap(in_snap), .out_word(out_word)
  );

  assign cur_state = state;
  assign err_code  = code;
endmodule

// File: rtl/slave_state_ctrl_chk.sv
module slave_state_ctrl_chk #(
  parameter int         DW        = 16,
  parameter logic [3:0] FILE_TYPE = 4'h4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          out_data_ok,
  input logic          wdog_en,
  input logic [3:0]    mbx_type,
  input logic [DW-1:0] in_word,
  input logic [3:0]    cur_state,
  input logic          ack,
  input logic          err,
  input logic [3:0]    err_code,
  input logic          mbx_en,
  input logic          pd_en,
  input logic [DW-1:0] in_snap,
  input logic [DW-1:0] out_word
);
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h8});

  a_r3_boot_from_init: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'h3 && $past(cur_state) != 4'h3) |-> $past(cur_state) == 4'h1);

  a_r5_snap_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err && cur_state == 4'h4 && $past(cur_state) == 4'h2) |-> in_snap == $past(in_word));

  a_r6_safe_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state inside {4'h1, 4'h2, 4'h3}) |-> out_word == '0);

  a_r7_op_needs_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'h8 && $past(cur_state) != 4'h8) |-> ($past(cur_state) == 4'h4 && $past(out_data_ok)));

  a_r9_boot_gating: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'h3 && mbx_type != FILE_TYPE) |-> (!mbx_en && !pd_en));

  a_r10_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ack);

  a_r10_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && err) |-> (cur_state == $past(cur_state) && err_code != 4'h0));

  a_r11_leave_op_safe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_state) == 4'h8 && cur_state != 4'h8 && !(cur_state == 4'h4 && !wdog_en)) |-> out_word == '0);
endmodule

bind slave_state_ctrl slave_state_ctrl_chk #(.DW(DW), .FILE_TYPE(FILE_TYPE)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .out_data_ok(out_data_ok),
  .wdog_en(wdog_en), .mbx_type(mbx_type), .in_word(in_word),
  .cur_state(cur_state), .ack(ack), .err(err), .err_code(err_code),
  .mbx_en(mbx_en), .pd_en(pd_en), .in_snap(in_snap), .out_word(out_word)
);

// File: tb/test_slave_state_ctrl.sv
`timescale 1ns/1ps
module test_slave_state_ctrl;
  localparam int DW = 16;
  localparam logic [3:0] S_INIT = 4'h1, S_PRE = 4'h2, S_BOOT = 4'h3, S_SAFE = 4'h4, S_OP = 4'h8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_state = 4'h0;
  logic chan_cfg_ok = 1'b0, clk_sync_en = 1'b0, clk_cfg_ok = 1'b0;
  logic wdog_en = 1'b1, out_data_ok = 1'b0;
  logic [3:0] mbx_type = 4'h0;
  logic [DW-1:0] in_word = '0, master_word = '0;
  logic [3:0] cur_state, err_code;
  logic ack, err, mbx_en, pd_en;
  logic [DW-1:0] in_snap, out_word;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  slave_state_ctrl #(.DW(DW)) i_slave_state_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .chan_cfg_ok(chan_cfg_ok), .clk_sync_en(clk_sync_en), .clk_cfg_ok(clk_cfg_ok),
    .wdog_en(wdog_en), .out_data_ok(out_data_ok), .mbx_type(mbx_type),
    .in_word(in_word), .master_word(master_word), .cur_state(cur_state),
    .ack(ack), .err(err), .err_code(err_code), .mbx_en(mbx_en), .pd_en(pd_en),
    .in_snap(in_snap), .out_word(out_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, registered at the rising edge, sampled on the next falling edge
  task automatic request(input logic [3:0] code);
    req_valid = 1'b1;
    req_state = code;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_result(input string tag, input logic [3:0] st, input logic e, input logic [3:0] code);
    chk({tag, " state"}, cur_state, st);
    chk({tag, " ack"}, ack, 1'b1);
    chk({tag, " err"}, err, e);
    chk({tag, " code"}, err_code, code);
  endtask

  task automatic t_reset;
    chk("R1 state", cur_state, S_INIT);
    chk("R1 ack", ack, 0);
    chk("R1 err", {err, err_code}, 0);
    chk("R1 enables", {mbx_en, pd_en}, 0);
    chk("R1 out", out_word, 0);
  endtask

  task automatic t_refusals_from_init;
    request(4'h5);
    expect_result("R2 invalid code", S_INIT, 1, 4'h1);
    @(negedge clk);
    chk("R10 ack one cycle", ack, 0);
    request(S_SAFE);
    expect_result("R12 init to safe", S_INIT, 1, 4'h1);
    request(S_OP);
    expect_result("R12 init to op", S_INIT, 1, 4'h1);
  endtask

  task automatic t_boot;
    request(S_BOOT);
    expect_result("R3 init to boot / R10 clear", S_BOOT, 0, 4'h0);
    mbx_type = 4'h4;
    #0.5;
    chk("R9 boot file mbx", mbx_en, 1);
    mbx_type = 4'h2;
    #0.5;
    chk("R9 boot other mbx", mbx_en, 0);
    chk("R9 boot pd", pd_en, 0);
    chk("R6 boot out", out_word, 0);
    @(negedge clk);
    request(S_PRE);
    expect_result("R3 boot to preop", S_BOOT, 1, 4'h1);
    request(S_INIT);
    expect_result("R3 boot to init", S_INIT, 0, 4'h0);
    chk("R9 init mbx", {mbx_en, pd_en}, 0);
  endtask

  task automatic t_preop;
    request(S_PRE);
    expect_result("R12 init to preop", S_PRE, 0, 4'h0);
    chk("R9 preop mbx any type", {mbx_en, pd_en}, 2'b10);
    request(S_BOOT);
    expect_result("R3 preop to boot", S_PRE, 1, 4'h1);
    request(S_OP);
    expect_result("R12 preop to op", S_PRE, 1, 4'h1);
    in_word = 16'h1234;
    @(negedge clk);
    chk("R5 hold in preop", in_snap, 16'h0000);
  endtask

  task automatic t_safeop;
    chan_cfg_ok = 1'b0;
    request(S_SAFE);
    expect_result("R4 channel invalid", S_PRE, 1, 4'h2);
    chan_cfg_ok = 1'b1; clk_sync_en = 1'b1; clk_cfg_ok = 1'b0;
    request(S_SAFE);
    expect_result("R4 clock invalid", S_PRE, 1, 4'h2);
    clk_cfg_ok = 1'b1; in_word = 16'hA5C3; master_word = 16'h0F0F; wdog_en = 1'b1;
    request(S_SAFE);
    expect_result("R4 accepted", S_SAFE, 0, 4'h0);
    chk("R5 snapshot on entry", in_snap, 16'hA5C3);
    chk("R6 wdog on out", out_word, 0);
    chk("R5 safeop enables", {mbx_en, pd_en}, 2'b11);
    in_word = 16'h5555;
    @(negedge clk);
    chk("R5 refresh in safeop", in_snap, 16'h5555);
    wdog_en = 1'b0;
    #0.5;
    chk("R6 wdog off out", out_word, 16'h0F0F);
    wdog_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_op;
    out_data_ok = 1'b0;
    request(S_OP);
    expect_result("R7 outputs missing", S_SAFE, 1, 4'h3);
    out_data_ok = 1'b1;
    request(S_OP);
    expect_result("R7 accepted", S_OP, 0, 4'h0);
    chk("R8 out follows", out_word, 16'h0F0F);
    chk("R8 enables", {mbx_en, pd_en}, 2'b11);
    master_word = 16'hBEEF;
    #0.5;
    chk("R8 out live", out_word, 16'hBEEF);
    in_word = 16'h7777;
    @(negedge clk);
    chk("R5 refresh in op", in_snap, 16'h7777);
  endtask

  task automatic t_downward;
    request(S_SAFE);
    expect_result("R11 op to safeop", S_SAFE, 0, 4'h0);
    chk("R11 op to safeop out", out_word, 0);
    out_data_ok = 1'b1;
    request(S_OP);
    expect_result("R11 back to op", S_OP, 0, 4'h0);
    request(S_INIT);
    expect_result("R11 op to init", S_INIT, 0, 4'h0);
    chk("R11 out zero", out_word, 0);
    in_word = 16'h0001;
    @(negedge clk);
    chk("R5 hold after leaving op", in_snap, 16'h7777);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refusals_from_init();
    t_boot();
    t_preop();
    t_safeop();
    t_op();
    t_downward();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule